// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the bus-facing register layer of a serial port. A 16-bit register bus reaches two offsets. Offset 0x00 behaves as two separate registers: a write loads the outgoing byte into a transmit holding register, and a read returns the last byte that the receiver delivered. Offset 0x04 is an interrupt-and-DMA enable register. The block combines these enables with status levels from the transmitter, the receiver, the line-status logic and the modem-status logic. From them it produces one interrupt line and two DMA request lines.

The shifters, the baud generator and the DMA controller sit outside this block. The transmitter takes the held byte through a valid/ready handshake. The receiver presents each finished byte with a one-cycle valid strobe. Every interrupt source is a level: it is the AND of its enable bit and its current status. Setting an enable while its condition already holds therefore raises the line at once.

Top module: `uart_regfront`

## Requirements
- R1: After reset the enable register reads 0x0000, the receive buffer reads 0x0000, the transmit holding register is empty (`tx_valid` low), and `irq`, `dma_tx_req` and `dma_rx_req` are low.
- R2: A bus write to offset 0x00 stores `bus_wdata[7:0]` in the transmit holding register. From the next cycle `tx_valid` is high and `tx_data` shows that byte. `bus_wdata[15:8]` is ignored.
- R3: A cycle in which `tx_valid` and `tx_ready` are both high hands the byte over, and the holding register is empty from the next cycle. A bus write in that same cycle keeps it full with the new byte.
- R4: An `rx_valid` strobe stores `rx_data` and sets buffer-full from the next cycle. A bus read at offset 0x00 returns `{8'h00, byte}` and clears buffer-full at the end of the read cycle, unless `rx_valid` arrives in that same cycle.
- R5: A write to offset 0x04 stores `bus_wdata[5:0]`. A read returns them with bits [15:6] zero. Bit 0 is the receive-full enable, bit 1 transmit-empty, bit 2 line status, bit 3 modem status, bit 4 transmit DMA and bit 5 receive DMA. Every read on the bus returns zero in bits [15:8].
- R6: With bit 0 set, `irq` is high while the buffer is full. It is low during a read cycle at offset 0x00, so the acknowledge removes the source in the cycle it happens.
- R7: With bit 1 set, `irq` is high while the holding register is empty, including straight after the enable is written.
- R8: With bit 2 set, `irq` follows the `line_stat` level input.
- R9: With bit 3 set, `irq` is high while any bit of `modem_chg[3:0]` is high.
- R10: `dma_tx_req` is high when the register is empty and bit 4 is set. `dma_rx_req` is high when the buffer is full and bit 5 is set. Bits 4 and 5 never drive `irq`.
- R11: Writes to any offset other than 0x00 and 0x04 change no state, and reads from such offsets return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Holding register holds a byte |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| line_stat | input | 1 | Line-status condition level |
| modem_chg | input | 4 | Modem-status change flags |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that `rx_valid` is a single-cycle strobe. They also assume that the status inputs and `tx_ready` are steady levels between edges, and that a bus access lasts exactly one cycle with `bus_sel` qualifying `bus_wr` and `bus_addr`. The stimulus drives every input at the falling edge and holds it for whole cycles. It pulses `rx_valid` and `tx_ready` for one cycle each. Between bus accesses it returns `bus_sel` to zero, so no read at offset 0x00 acknowledges the buffer by accident.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;
    localparam int EN_W   = 6;
    localparam int NUM_IRQ_SRC = 4;

    localparam logic [ADDR_W-1:0] OFF_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_EN   = 4'h4;

    typedef struct packed {
        logic rx_dma_en;
        logic tx_dma_en;
        logic modem_ie;
        logic line_ie;
        logic tx_empty_ie;
        logic rx_full_ie;
    } en_reg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_EN
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] off);
        case (off)
            OFF_DATA: return SEL_DATA;
            OFF_EN:   return SEL_EN;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/urf_tx_hold.sv
module urf_tx_hold
    import uart_regfront_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         full,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (full && ready) begin
            full <= 1'b0;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (full && dout == $past(din)));

    assert_drain_R3: assert property (@(posedge clk) disable iff (rst)
        (full && ready && !load) |=> !full);

endmodule

// File: rtl/urf_rx_buf.sv
module urf_rx_buf
    import uart_regfront_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] din,
    input  logic         ack,
    output logic         full,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else if (strobe) begin
            full <= 1'b1;
            dout <= din;
        end else if (ack) begin
            full <= 1'b0;
        end
    end

    assert_fill_R4: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (full && dout == $past(din)));

    assert_ack_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && !strobe) |=> !full);

endmodule

// File: rtl/urf_irq_dma.sv
module urf_irq_dma
    import uart_regfront_pkg::*;
#(
    parameter int N_MODEM = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  en_reg_t            en,
    input  logic               rx_full,
    input  logic               rx_ack,
    input  logic               tx_empty,
    input  logic               line_evt,
    input  logic [N_MODEM-1:0] modem_chg,
    output logic               irq,
    output logic               dma_tx,
    output logic               dma_rx
);

    logic [NUM_IRQ_SRC-1:0] src_lvl;
    logic [NUM_IRQ_SRC-1:0] src_en;
    logic [NUM_IRQ_SRC-1:0] src_act;

    always_comb begin
        src_lvl[0] = rx_full && !rx_ack;
        src_lvl[1] = tx_empty;
        src_lvl[2] = line_evt;
        src_lvl[3] = |modem_chg;
        src_en     = {en.modem_ie, en.line_ie, en.tx_empty_ie, en.rx_full_ie};
    end

    for (genvar i = 0; i < NUM_IRQ_SRC; i++) begin : g_src
        assign src_act[i] = src_en[i] & src_lvl[i];
    end

    assign irq    = |src_act;
    assign dma_tx = en.tx_dma_en && tx_empty;
    assign dma_rx = en.rx_dma_en && rx_full;

    assert_immediate_R7: assert property (@(posedge clk) disable iff (rst)
        (en.tx_empty_ie && tx_empty) |-> irq);

    assert_modem_R9: assert property (@(posedge clk) disable iff (rst)
        (en.modem_ie && modem_chg != '0) |-> irq);

    assert_dma_no_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (!en.rx_full_ie && !en.tx_empty_ie && !en.line_ie && !en.modem_ie) |-> !irq);

    assert_ack_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_ack && !en.tx_empty_ie && !en.line_ie && !en.modem_ie) |-> !irq);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              line_stat,
    input  logic [3:0]        modem_chg,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);

    reg_sel_e            sel;
    logic                wr_data, wr_en, rd_data;
    en_reg_t             en_q;
    logic                tx_full, rx_full;
    logic [BYTE_W-1:0]   rx_byte;
    logic                unused_hi;

    assign sel       = decode_off(bus_addr);
    assign wr_data   = bus_sel && bus_wr && sel == SEL_DATA;
    assign wr_en     = bus_sel && bus_wr && sel == SEL_EN;
    assign rd_data   = bus_sel && !bus_wr && sel == SEL_DATA;
    assign unused_hi = ^bus_wdata[BUS_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else if (wr_en) en_q <= en_reg_t'(bus_wdata[EN_W-1:0]);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (sel)
                SEL_DATA: bus_rdata[BYTE_W-1:0] = rx_byte;
                SEL_EN:   bus_rdata[EN_W-1:0]   = en_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    urf_tx_hold #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst(rst), .load(wr_data), .din(bus_wdata[BYTE_W-1:0]),
        .ready(tx_ready), .full(tx_full), .dout(tx_data)
    );

    urf_rx_buf #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst(rst), .strobe(rx_valid), .din(rx_data),
        .ack(rd_data), .full(rx_full), .dout(rx_byte)
    );

    urf_irq_dma #(.N_MODEM(4)) u_irq (
        .clk(clk), .rst(rst), .en(en_q), .rx_full(rx_full), .rx_ack(rd_data),
        .tx_empty(!tx_full), .line_evt(line_stat), .modem_chg(modem_chg),
        .irq(irq), .dma_tx(dma_tx_req), .dma_rx(dma_rx_req)
    );

    assign tx_valid = tx_full;

    assert_reserved_R5: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:BYTE_W] == '0);

    assert_unmapped_rd_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && sel == SEL_NONE) |-> bus_rdata == '0);

    assert_unmapped_wr_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && sel == SEL_NONE) |=> $stable(en_q));

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && !tx_valid && !dma_tx_req && !dma_rx_req));

endmodule

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        tx_valid, tx_ready, rx_valid, line_stat;
    logic [7:0]  tx_data, rx_data;
    logic [3:0]  modem_chg;
    logic        irq, dma_tx_req, dma_rx_req;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_regfront dut (.*);

    // {is_write, addr, data, expected read}
    localparam int NV = 11;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 4'h0, 16'h0000, 16'h0000},
        {1'b1, 4'h4, 16'hFFFF, 16'h0000},
        {1'b0, 4'h4, 16'h0000, 16'h003F},
        {1'b1, 4'h8, 16'h0000, 16'h0000},
        {1'b0, 4'h4, 16'h0000, 16'h003F},
        {1'b0, 4'h8, 16'h0000, 16'h0000},
        {1'b0, 4'hC, 16'h0000, 16'h0000},
        {1'b1, 4'h4, 16'h002A, 16'h0000},
        {1'b0, 4'h4, 16'h0000, 16'h002A},
        {1'b1, 4'h4, 16'h0000, 16'h0000},
        {1'b0, 4'h4, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d, output logic irq_s);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5;
        d = bus_rdata; irq_s = irq;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        irq_s;
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        tx_ready = 0; rx_valid = 0; rx_data = 0; line_stat = 0; modem_chg = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R1 dma", {14'd0, dma_tx_req, dma_rx_req}, 16'd0);

        // table walk: R5 enable map, R11 unmapped offsets
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) begin
                bus_write(VEC[i][35:32], VEC[i][31:16]);
            end else begin
                bus_read(VEC[i][35:32], rd, irq_s);
                check("R5/R11/R1 table read", rd, VEC[i][15:0]);
            end
        end

        // R11: unmapped write does not load the holding register
        bus_write(4'h8, 16'h00AA);
        check("R11 tx_valid after unmapped write", {15'd0, tx_valid}, 16'd0);

        // R7: enabling the empty source raises irq at once
        bus_write(4'h4, 16'h0002);
        check("R7 immediate irq", {15'd0, irq}, 16'd1);

        // R2: write the holding register, upper byte ignored
        bus_write(4'h0, 16'hAB5C);
        check("R2 tx_valid", {15'd0, tx_valid}, 16'd1);
        check("R2 tx_data", {8'd0, tx_data}, 16'h005C);
        check("R7 irq low while full", {15'd0, irq}, 16'd0);

        // R3: handshake empties it
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check("R3 tx_valid after handshake", {15'd0, tx_valid}, 16'd0);
        check("R3 irq after handshake", {15'd0, irq}, 16'd1);

        // R10: transmit DMA gating, no irq from DMA bits
        bus_write(4'h4, 16'h0010);
        check("R10 dma_tx_req", {15'd0, dma_tx_req}, 16'd1);
        check("R10 irq off with only dma bits", {15'd0, irq}, 16'd0);

        // R4/R6/R10: receive path
        pulse_rx(8'hC3);
        check("R10 dma_rx_req gated off", {15'd0, dma_rx_req}, 16'd0);
        bus_write(4'h4, 16'h0021);
        check("R6 irq immediate on full", {15'd0, irq}, 16'd1);
        check("R10 dma_rx_req", {15'd0, dma_rx_req}, 16'd1);
        bus_read(4'h0, rd, irq_s);
        check("R4 read data", rd, 16'h00C3);
        check("R6 irq masked in read cycle", {15'd0, irq_s}, 16'd0);
        check("R4 full cleared", {15'd0, dma_rx_req}, 16'd0);
        check("R6 irq after read", {15'd0, irq}, 16'd0);

        // R8: line status level
        bus_write(4'h4, 16'h0004);
        @(negedge clk); line_stat = 1'b1; #5;
        check("R8 irq on line status", {15'd0, irq}, 16'd1);
        @(negedge clk); line_stat = 1'b0; #5;
        check("R8 irq follows level", {15'd0, irq}, 16'd0);

        // R9: modem change bits
        bus_write(4'h4, 16'h0008);
        @(negedge clk); modem_chg = 4'b0100; #5;
        check("R9 irq on modem bit", {15'd0, irq}, 16'd1);
        @(negedge clk); modem_chg = 4'b0000; #5;
        check("R9 irq clears", {15'd0, irq}, 16'd0);
        bus_write(4'h4, 16'h0000);
        @(negedge clk); modem_chg = 4'b1000; line_stat = 1'b1; #5;
        check("R9/R8 disabled sources", {15'd0, irq}, 16'd0);
        @(negedge clk); modem_chg = 0; line_stat = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule